// File: doc/BRIEF.md
# JTAG Byte Memory Access Port

This block is a four-wire serial test-port slave whose only purpose is to reach an internal byte-wide register and memory space. It has no boundary scan. A host moves the 16-state TAP controller with TMS and selects a data register through a 5-bit instruction. It can read an identification word and a user word. Three dedicated 8-bit registers let it set a memory address, write one byte and read one byte.

The block runs entirely in the system clock domain. TCK, TMS and TDI are treated as slow inputs: they pass through a two-flop synchronizer, and TCK edges are detected from the synchronized samples. The memory side is a simple synchronous request port with one-cycle read latency. An external arbiter gives the memory to one host interface at a time through `mem_grant`. While the grant is low, this port neither writes nor reads.

TCK high and low phases must each last at least 8 system clock cycles.

Top module: `jtag_mem_port`

## Requirements
- R1: After `rst`, the controller is in Test-Logic-Reset, `tdo_oe` is low, and the current instruction is IDCODE (00000).
- R2: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state, and the instruction reverts to IDCODE.
- R3: The instruction shift stage is 5 bits long and loads 5'b00001 in Capture-IR. That value comes out on TDO least significant bit first. The current instruction changes only at the TCK falling edge in Update-IR.
- R4: IDCODE (00000) selects the 32-bit `ID_VALUE` and USERCODE (00011) selects the 32-bit `USER_VALUE`. Both are captured in Capture-DR and shifted out least significant bit first.
- R5: BYPASS (11111) and every opcode other than 00000, 00011, 00100, 00101 and 00110 select a 1-bit register. That register captures 0.
- R6: LOAD ADDRESS (00100) selects an 8-bit register. It captures the current `mem_addr`, and Update-DR sets `mem_addr` to the last 8 bits shifted in.
- R7: WRITE DATA (00110) selects an 8-bit register that captures the last written byte. Update-DR puts the shifted byte on `mem_wdata` and raises `mem_we` for exactly one clock cycle.
- R8: READ DATA (00101) selects an 8-bit register. On entry to Capture-DR the port raises `mem_re` for one clock cycle, and the byte returned one cycle later is shifted out.
- R9: With `mem_grant` low, neither `mem_we` nor `mem_re` is raised, and a READ DATA capture yields 0x00.
- R10: In Test-Logic-Reset, the held write byte and read byte are cleared to 0x00.
- R11: TDO and `tdo_oe` change only after a TCK falling edge. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R12: Pausing a data scan in Pause-DR keeps the shift contents, and the scan resumes from the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Test clock, sampled by `clk` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| mem_grant | input | 1 | Arbiter grant: this port owns the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_re` |

## Verification
A wrong controller state shows up within one TCK period as a shifted or truncated serial pattern. It also shows as `tdo_oe` rising outside a shift. The sweep drives every one of the 32 opcodes through a 40-bit data scan, so a wrong length or wrong capture source shows as a bit misplacement at a precise offset. A wrong address latch or strobe shows up at the memory side on the same Update-DR edge. It is then seen on TDO at the next READ DATA capture, which is one scan later.

// File: rtl/jtag_mem_pkg.sv
`timescale 1ns/1ps
package jtag_mem_pkg;
  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00000;
  localparam logic [IR_W-1:0] OP_USERCODE = 5'b00011;
  localparam logic [IR_W-1:0] OP_LDADDR   = 5'b00100;
  localparam logic [IR_W-1:0] OP_RDDATA   = 5'b00101;
  localparam logic [IR_W-1:0] OP_WRDATA   = 5'b00110;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    SEL_BYP, SEL_ID, SEL_USR, SEL_ADR, SEL_WR, SEL_RD
  } dr_sel_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TS_TLR:    n = m ? TS_TLR    : TS_RTI;
      TS_RTI:    n = m ? TS_SEL_DR : TS_RTI;
      TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: n = m ? TS_SEL_DR : TS_RTI;
      TS_SEL_IR: n = m ? TS_TLR    : TS_CAP_IR;
      TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: n = m ? TS_SEL_DR : TS_RTI;
      default:   n = TS_TLR;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    dr_sel_e d;
    case (op)
      OP_IDCODE:   d = SEL_ID;
      OP_USERCODE: d = SEL_USR;
      OP_LDADDR:   d = SEL_ADR;
      OP_RDDATA:   d = SEL_RD;
      OP_WRDATA:   d = SEL_WR;
      default:     d = SEL_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tck_rise,
  input  logic       tms_s,
  output tap_state_e st,
  output logic       st_new
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TS_TLR;
      st_new <= 1'b0;
    end else begin
      st_new <= tck_rise;
      if (tck_rise) st <= tap_next(st, tms_s);
    end
  end

  // run length of TMS-high rising edges, saturating, for the reset check
  logic [2:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (tck_rise) hi_run <= tms_s ? ((hi_run == 3'd7) ? hi_run : hi_run + 3'd1) : 3'd0;
  end

  assert_five_high_tlr_R2: assert property (@(posedge clk) disable iff (rst)
    (hi_run >= 3'd5) |-> (st == TS_TLR));
endmodule

// File: rtl/jtag_ir.sv
`timescale 1ns/1ps
module jtag_ir
  import jtag_mem_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tck_rise,
  input  logic            tck_fall,
  input  tap_state_e      st,
  input  logic            tdi_s,
  output logic            ir_tdo,
  output logic [IR_W-1:0] instr
);
  localparam logic [IR_W-1:0] CAPT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= CAPT;
      instr <= OP_IDCODE;
    end else begin
      if (tck_rise && st == TS_CAP_IR)      sr <= CAPT;
      else if (tck_rise && st == TS_SHF_IR) sr <= {tdi_s, sr[IR_W-1:1]};
      if (st == TS_TLR)                          instr <= OP_IDCODE;
      else if (tck_fall && st == TS_UPD_IR)      instr <= sr;
    end
  end

  assign ir_tdo = sr[0];

  assert_ir_hold_in_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (st == TS_SHF_IR) |=> $stable(instr));
  assert_idcode_in_tlr_R2: assert property (@(posedge clk) disable iff (rst)
    (st == TS_TLR) |=> (instr == OP_IDCODE));
endmodule

// File: rtl/jtag_dr_bank.sv
`timescale 1ns/1ps
module jtag_dr_bank
  import jtag_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h1A5C_E0B3,
  parameter logic [ID_W-1:0] USER_VALUE = 32'h0000_C0DE
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tck_rise,
  input  logic              tck_fall,
  input  tap_state_e        st,
  input  logic              st_new,
  input  logic [IR_W-1:0]   instr,
  input  logic              tdi_s,
  input  logic              mem_grant,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dr_tdo,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  localparam int SR_W  = ID_W;
  localparam int LEN_W = $clog2(SR_W + 1);

  dr_sel_e           sel;
  logic [SR_W-1:0]   sr, cap, shifted, top;
  logic [LEN_W-1:0]  len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_hold;
  logic              rd_pend;

  assign sel = decode_op(instr);

  always_comb begin
    cap = '0;
    case (sel)
      SEL_ID:  cap = ID_VALUE;
      SEL_USR: cap = USER_VALUE;
      SEL_ADR: cap[ADDR_W-1:0] = addr_q;
      SEL_WR:  cap[DATA_W-1:0] = wdata_q;
      SEL_RD:  cap[DATA_W-1:0] = rd_hold;
      default: cap = '0;
    endcase
    case (sel)
      SEL_ID, SEL_USR: len = LEN_W'(ID_W);
      SEL_ADR:         len = LEN_W'(ADDR_W);
      SEL_WR, SEL_RD:  len = LEN_W'(DATA_W);
      default:         len = LEN_W'(1);
    endcase
    top     = {{(SR_W-1){1'b0}}, 1'b1} << (len - LEN_W'(1));
    shifted = ((sr >> 1) & ~top) | (tdi_s ? top : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_hold <= '0;
      rd_pend <= 1'b0;
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;
      if (tck_rise && st == TS_CAP_DR)      sr <= cap;
      else if (tck_rise && st == TS_SHF_DR) sr <= shifted;
      if (tck_fall && st == TS_UPD_DR) begin
        if (sel == SEL_ADR) addr_q <= sr[ADDR_W-1:0];
        if (sel == SEL_WR) begin
          wdata_q <= sr[DATA_W-1:0];
          mem_we  <= mem_grant;
        end
      end
      if (st_new && st == TS_CAP_DR && sel == SEL_RD) begin
        if (mem_grant) mem_re  <= 1'b1;
        else           rd_hold <= '0;
      end
      if (rd_pend) rd_hold <= mem_rdata;
      if (st == TS_TLR) begin
        wdata_q <= '0;
        rd_hold <= '0;
      end
    end
  end

  assign dr_tdo    = sr[0];
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_re_single_R8: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
  assert_we_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_grant));
  assert_re_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> $past(mem_grant));
endmodule

// File: rtl/jtag_mem_port.sv
`timescale 1ns/1ps
module jtag_mem_port
  import jtag_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h1A5C_E0B3,
  parameter logic [ID_W-1:0] USER_VALUE = 32'h0000_C0DE
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              mem_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic tck_m, tck_s, tck_d, tms_m, tms_s, tdi_m, tdi_s;
  logic tck_rise, tck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      {tck_m, tck_s, tck_d} <= '0;
      {tms_m, tms_s}        <= 2'b11;
      {tdi_m, tdi_s}        <= '0;
    end else begin
      tck_m <= tck;  tck_s <= tck_m;  tck_d <= tck_s;
      tms_m <= tms;  tms_s <= tms_m;
      tdi_m <= tdi;  tdi_s <= tdi_m;
    end
  end

  assign tck_rise = tck_s & ~tck_d;
  assign tck_fall = ~tck_s & tck_d;

  tap_state_e      st;
  logic            st_new, ir_tdo, dr_tdo;
  logic [IR_W-1:0] instr;

  jtag_tap_fsm u_fsm (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tms_s(tms_s),
    .st(st), .st_new(st_new)
  );

  jtag_ir u_ir (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .st(st), .tdi_s(tdi_s), .ir_tdo(ir_tdo), .instr(instr)
  );

  jtag_dr_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .ID_VALUE(ID_VALUE), .USER_VALUE(USER_VALUE)
  ) u_dr (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .st(st), .st_new(st_new), .instr(instr), .tdi_s(tdi_s),
    .mem_grant(mem_grant), .mem_rdata(mem_rdata), .dr_tdo(dr_tdo),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (tck_fall) begin
      tdo_oe <= (st == TS_SHF_IR) || (st == TS_SHF_DR);
      tdo    <= (st == TS_SHF_IR) ? ir_tdo : dr_tdo;
    end
  end

  assert_oe_only_shift_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(tdo_oe) |-> (st == TS_SHF_IR || st == TS_SHF_DR));
  assert_tdo_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !tck_fall |=> ($stable(tdo) && $stable(tdo_oe)));
endmodule

// File: tb/tb_jtag_mem_port.sv
`timescale 1ns/1ps
module tb_jtag_mem_port;
  localparam int HALF = 8;
  localparam logic [31:0] IDV  = 32'h1A5C_E0B3;
  localparam logic [31:0] USRV = 32'h0000_C0DE;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tck = 1'b0, tms = 1'b1, tdi = 1'b0, grant = 1'b0;
  logic tdo, tdo_oe, mem_we, mem_re;
  logic [7:0] mem_addr, mem_wdata, rdata;
  logic [7:0] mem [256];
  int we_cnt;
  int total = 0, bad = 0, glitch = 0;

  jtag_mem_port dut (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .mem_grant(grant), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) rdata <= mem[mem_addr];
  end
  always_ff @(posedge clk) begin
    if (rst) we_cnt <= 0;
    else if (mem_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one TCK period; o is TDO just before the rising edge
  task automatic cyc(input logic m, input logic d, output logic o);
    logic pre;
    tms = m; tdi = d;
    repeat (HALF) @(negedge clk);
    o = tdo; pre = tdo;
    tck = 1'b1;
    repeat (HALF) @(negedge clk);
    if (tdo !== pre) glitch++;
    tck = 1'b0;
  endtask

  task automatic cy(input logic m);
    logic o;
    cyc(m, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [4:0] op);
    logic [4:0] co;
    logic o;
    cy(1); cy(1); cy(0); cy(0);
    for (int i = 0; i < 5; i++) begin
      cyc(i == 4, op[i], o);
      co[i] = o;
    end
    cy(1); cy(0);
    chk(co == 5'b00001, "R3 capture-IR pattern", 64'(co), 64'h1);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, input int pause_at, output logic [63:0] dout);
    logic o;
    dout = '0;
    cy(1); cy(0); cy(0);
    for (int i = 0; i < n; i++) begin
      cyc((i == n-1) || (i == pause_at-1), din[i], o);
      dout[i] = o;
      if (i == pause_at-1 && i != n-1) begin
        cy(0); cy(0);
        chk(tdo_oe == 1'b0, "R11 oe low in pause", 64'(tdo_oe), 64'h0);
        cy(1); cy(0);
      end
    end
    cy(1); cy(0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [63:0] expect_scan(input int len, input logic [63:0] cap, input logic [63:0] din, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i-len];
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] dout, din, ex;
    logic [7:0] exp_addr, exp_wr, a, d, prev_a, prev_d;
    int wc;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(tdo_oe == 1'b0, "R1 oe after reset", 64'(tdo_oe), 64'h0);
    cy(0);
    dr_scan(32, 64'h0, -1, dout);
    chk(dout[31:0] == IDV, "R1 default IDCODE", dout, 64'(IDV));
    chk(tdo_oe == 1'b0, "R11 oe low in idle", 64'(tdo_oe), 64'h0);

    ir_scan(5'b00011);
    dr_scan(32, 64'h0, -1, dout);
    chk(dout[31:0] == USRV, "R4 USERCODE", dout, 64'(USRV));

    // all opcodes, grant low, 40-bit scans
    exp_addr = 8'h00; exp_wr = 8'h00; wc = we_cnt;
    for (int op = 0; op < 32; op++) begin
      din = 64'(40'h9D_3C5A_E1F7 ^ (40'(op) * 40'h01_0101_0101));
      ir_scan(5'(op));
      dr_scan(40, din, -1, dout);
      case (op)
        0:       ex = expect_scan(32, 64'(IDV), din, 40);
        3:       ex = expect_scan(32, 64'(USRV), din, 40);
        4:       ex = expect_scan(8, 64'(exp_addr), din, 40);
        5:       ex = expect_scan(8, 64'h0, din, 40);
        6:       ex = expect_scan(8, 64'(exp_wr), din, 40);
        default: ex = expect_scan(1, 64'h0, din, 40);
      endcase
      if (op == 4) exp_addr = din[39:32];
      if (op == 6) exp_wr = din[39:32];
      chk(dout[39:0] == ex[39:0], (op == 0 || op == 3) ? "R4 opcode sweep" :
          (op == 4) ? "R6 opcode sweep" : (op == 5) ? "R9 read without grant" :
          (op == 6) ? "R7 opcode sweep" : "R5 bypass sweep", dout, ex);
    end
    chk(we_cnt == wc, "R9 no write without grant", 64'(we_cnt), 64'(wc));

    // memory sweep with grant
    grant = 1'b1;
    prev_a = exp_addr; prev_d = exp_wr;
    for (int i = 0; i < 32; i++) begin
      a = 8'(i * 8 + 3); d = 8'(int'(a) * 37 + 11);
      ir_scan(5'b00100);
      dr_scan(8, 64'(a), -1, dout);
      chk(dout[7:0] == prev_a, "R6 address capture", dout, 64'(prev_a));
      ir_scan(5'b00110);
      wc = we_cnt;
      dr_scan(8, 64'(d), -1, dout);
      chk(dout[7:0] == prev_d, "R7 write capture", dout, 64'(prev_d));
      chk(we_cnt == wc + 1, "R7 single strobe", 64'(we_cnt), 64'(wc + 1));
      chk(mem[a] == d, "R7 byte stored", 64'(mem[a]), 64'(d));
      prev_a = a; prev_d = d;
    end
    for (int i = 0; i < 32; i++) begin
      a = 8'(i * 8 + 3); d = 8'(int'(a) * 37 + 11);
      ir_scan(5'b00100);
      dr_scan(8, 64'(a), -1, dout);
      ir_scan(5'b00101);
      dr_scan(8, 64'h0, -1, dout);
      chk(dout[7:0] == d, "R8 read back", dout, 64'(d));
    end

    // write attempt without grant leaves memory
    grant = 1'b0;
    ir_scan(5'b00100);
    dr_scan(8, 64'h03, -1, dout);
    ir_scan(5'b00110);
    wc = we_cnt;
    dr_scan(8, 64'h5A, -1, dout);
    chk(we_cnt == wc, "R9 write suppressed", 64'(we_cnt), 64'(wc));
    grant = 1'b1;
    ir_scan(5'b00101);
    dr_scan(8, 64'h0, -1, dout);
    chk(dout[7:0] == 8'(3 * 37 + 11), "R9 memory unchanged", dout, 64'(8'(3 * 37 + 11)));

    // pause in the middle of a data scan
    ir_scan(5'b00000);
    dr_scan(32, 64'h0, 10, dout);
    chk(dout[31:0] == IDV, "R12 pause keeps data", dout, 64'(IDV));

    // reset from shift-DR by five TMS-high edges
    ir_scan(5'b11111);
    cy(1); cy(0); cy(0);
    for (int k = 0; k < 5; k++) cy(1);
    cy(0);
    dr_scan(32, 64'h0, -1, dout);
    chk(dout[31:0] == IDV, "R2 reset to IDCODE", dout, 64'(IDV));

    // write latch cleared by Test-Logic-Reset
    ir_scan(5'b00110);
    dr_scan(8, 64'hE7, -1, dout);
    for (int k = 0; k < 5; k++) cy(1);
    cy(0);
    ir_scan(5'b00110);
    dr_scan(8, 64'h0, -1, dout);
    chk(dout[7:0] == 8'h00, "R10 write latch cleared", dout, 64'h0);

    chk(glitch == 0, "R11 tdo steady while tck high", 64'(glitch), 64'h0);
    summary();
  end
endmodule